// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This unit applies one AES round transformation to a 128-bit state per operation, the way a processor's cipher instructions do. A 3-bit opcode picks the operation: a full encryption round, a final encryption round, a full decryption round, a final decryption round, or a standalone inverse column mix. The inverse column mix turns ordinary round keys into the keys that the decryption flow needs.

The unit does not hold a key schedule and does not loop over rounds. Software or a sequencer issues one operation per round, with the matching round key. Because of this, the same hardware serves 128-, 192- and 256-bit keys. Inputs are sampled on a valid strobe. The result is registered and appears one cycle later. The unit accepts a new operation on every cycle.

Top module: `aes_round_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 and `out_result` is all zeros after that edge.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. Operations on consecutive cycles each produce a result.
- R3: Opcode 3'b000 gives ShiftRows, then SubBytes, then MixColumns, then XOR with `in_key`.
- R4: Opcode 3'b001 gives ShiftRows, then SubBytes, then XOR with `in_key`, with no column mix.
- R5: Opcode 3'b010 gives InvShiftRows, then InvSubBytes, then InvMixColumns, then XOR with `in_key`.
- R6: Opcode 3'b011 gives InvShiftRows, then InvSubBytes, then XOR with `in_key`, with no column mix.
- R7: Opcode 3'b100 gives InvMixColumns of `in_state` alone, and `in_key` has no effect on the result.
- R8: Opcodes 3'b101, 3'b110 and 3'b111 return `in_state` unchanged, and `in_key` has no effect on the result.
- R9: State byte k sits in bits [8k+7:8k] and holds row k mod 4 of column k div 4. Byte 0 is the first byte of the standard test-vector strings.
- R10: In a cycle after one in which `in_valid` is low, `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code |
| in_state | input | 128 | State operand |
| in_key | input | 128 | Round-key operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 128 | Registered result |

## Verification
The bench builds the unit with its default of four columns, which is the only width AES defines. At that width, a published round-one vector can anchor the byte ordering. The bench also drives random states and keys through all eight opcode values. It mixes back-to-back operations with idle gaps, so the latency rule, the hold rule and the key-insensitive codes are all exercised. The reference model builds its substitution tables by brute-force field inversion and mixes columns by matrix multiply, so it shares no structure with the datapath.

// File: rtl/aes_round_pkg.sv
package aes_round_pkg;

  typedef enum logic [2:0] {
    OP_ENC       = 3'b000,
    OP_ENC_FINAL = 3'b001,
    OP_DEC       = 3'b010,
    OP_DEC_FINAL = 3'b011,
    OP_INV_MIX   = 3'b100
  } round_op_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // a^254 = a^-1 (and 0 -> 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] i;
    i = gf_inv(a);
    return i ^ rotl8(i, 1) ^ rotl8(i, 2) ^ rotl8(i, 3) ^ rotl8(i, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] a);
    return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

endpackage

// File: rtl/aes_byte_sub.sv
module aes_byte_sub #(
  parameter int NBYTES  = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  import aes_round_pkg::*;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (INVERSE) begin : g_inv
      assign dout[8*b +: 8] = sbox_inv(din[8*b +: 8]);
    end else begin : g_fwd
      assign dout[8*b +: 8] = sbox_fwd(din[8*b +: 8]);
    end
  end

endmodule

// File: rtl/aes_row_shift.sv
module aes_row_shift #(
  parameter int NCOL    = 4,
  parameter bit INVERSE = 1'b0
) (
  input  logic [32*NCOL-1:0] din,
  output logic [32*NCOL-1:0] dout
);
  localparam int NROW = 4;

  // row r rotates left by r columns (right by r when inverse)
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      localparam int SRC = INVERSE ? ((c - r + NCOL) % NCOL) : ((c + r) % NCOL);
      assign dout[8*(NROW*c + r) +: 8] = din[8*(NROW*SRC + r) +: 8];
    end
  end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix #(
  parameter int NCOL    = 4,
  parameter bit INVERSE = 1'b0
) (
  input  logic [32*NCOL-1:0] din,
  output logic [32*NCOL-1:0] dout
);
  import aes_round_pkg::*;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = din[32*c +  0 +: 8];
    assign a1 = din[32*c +  8 +: 8];
    assign a2 = din[32*c + 16 +: 8];
    assign a3 = din[32*c + 24 +: 8];
    if (INVERSE) begin : g_inv
      assign dout[32*c +  0 +: 8] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
      assign dout[32*c +  8 +: 8] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
      assign dout[32*c + 16 +: 8] = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
      assign dout[32*c + 24 +: 8] = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end else begin : g_fwd
      assign dout[32*c +  0 +: 8] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
      assign dout[32*c +  8 +: 8] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
      assign dout[32*c + 16 +: 8] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
      assign dout[32*c + 24 +: 8] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
    end
  end

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit #(
  parameter int NCOL = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           in_op,
  input  logic [32*NCOL-1:0]   in_state,
  input  logic [32*NCOL-1:0]   in_key,
  output logic                 out_valid,
  output logic [32*NCOL-1:0]   out_result
);
  import aes_round_pkg::*;

  localparam int NBYTES  = 4 * NCOL;
  localparam int STATE_W = 8 * NBYTES;

  logic [STATE_W-1:0] fwd_shift, fwd_sub, fwd_mix;
  logic [STATE_W-1:0] inv_shift, inv_sub, inv_mix_in, inv_mix;
  logic [STATE_W-1:0] next_result;
  round_op_e          op;

  assign op = round_op_e'(in_op);

  // encryption path
  aes_row_shift #(.NCOL(NCOL), .INVERSE(1'b0)) u_fwd_shift (.din(in_state),  .dout(fwd_shift));
  aes_byte_sub  #(.NBYTES(NBYTES), .INVERSE(1'b0)) u_fwd_sub (.din(fwd_shift), .dout(fwd_sub));
  aes_col_mix   #(.NCOL(NCOL), .INVERSE(1'b0)) u_fwd_mix   (.din(fwd_sub),   .dout(fwd_mix));

  // decryption path; the inverse mixer is shared with the standalone operation
  aes_row_shift #(.NCOL(NCOL), .INVERSE(1'b1)) u_inv_shift (.din(in_state),  .dout(inv_shift));
  aes_byte_sub  #(.NBYTES(NBYTES), .INVERSE(1'b1)) u_inv_sub (.din(inv_shift), .dout(inv_sub));
  assign inv_mix_in = (op == OP_INV_MIX) ? in_state : inv_sub;
  aes_col_mix   #(.NCOL(NCOL), .INVERSE(1'b1)) u_inv_mix   (.din(inv_mix_in), .dout(inv_mix));

  always_comb begin
    case (op)
      OP_ENC:       next_result = fwd_mix ^ in_key;
      OP_ENC_FINAL: next_result = fwd_sub ^ in_key;
      OP_DEC:       next_result = inv_mix ^ in_key;
      OP_DEC_FINAL: next_result = inv_sub ^ in_key;
      OP_INV_MIX:   next_result = inv_mix;
      default:      next_result = in_state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end

endmodule

// File: rtl/aes_round_unit_chk.sv
module aes_round_unit_chk #(
  parameter int STATE_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [2:0]         in_op,
  input logic [STATE_W-1:0] in_state,
  input logic               out_valid,
  input logic [STATE_W-1:0] out_result
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > 3'd4) |=> (out_result == $past(in_state)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

endmodule

bind aes_round_unit aes_round_unit_chk #(.STATE_W(32 * NCOL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_state   (in_state),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/aes_round_unit_bench.sv
module aes_round_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_result;

  int n_cmp = 0;
  int n_bad = 0;

  logic         exp_valid;
  logic [127:0] exp_result;
  string        exp_tag;

  logic [7:0] sb  [256];
  logic [7:0] isb [256];

  always #10 clk = ~clk;

  aes_round_unit u_aes_round_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_state(in_state), .in_key(in_key),
    .out_valid(out_valid), .out_result(out_result)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    int acc = 0;
    int aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa << 1;
      if (aa > 255) aa = aa ^ 'h11b;
    end
    return acc[7:0];
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (mul(x[7:0], y[7:0]) == 8'h01) iv = y[7:0];
      for (int i = 0; i < 8; i++)
        s[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = s;
    end
    for (int x = 0; x < 256; x++) isb[sb[x]] = x[7:0];
  endtask

  function automatic logic [7:0] gb(input logic [127:0] s, input int r, input int c);
    return s[8*(4*c + r) +: 8];
  endfunction

  function automatic logic [127:0] m_shift(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[8*(4*c + r) +: 8] = gb(s, r, inv ? (c + 4 - r) % 4 : (c + r) % 4);
    return o;
  endfunction

  function automatic logic [127:0] m_sub(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int k = 0; k < 16; k++) o[8*k +: 8] = inv ? isb[s[8*k +: 8]] : sb[s[8*k +: 8]];
    return o;
  endfunction

  function automatic logic [127:0] m_mix(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    logic [7:0] m [4];
    if (inv) begin m[0] = 8'h0e; m[1] = 8'h0b; m[2] = 8'h0d; m[3] = 8'h09; end
    else     begin m[0] = 8'h02; m[1] = 8'h03; m[2] = 8'h01; m[3] = 8'h01; end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 8'h00;
        for (int j = 0; j < 4; j++) acc = acc ^ mul(m[(j - r + 4) % 4], gb(s, j, c));
        o[8*(4*c + r) +: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k);
    case (op)
      3'd0: return m_mix(m_sub(m_shift(s, 0), 0), 0) ^ k;
      3'd1: return m_sub(m_shift(s, 0), 0) ^ k;
      3'd2: return m_mix(m_sub(m_shift(s, 1), 1), 1) ^ k;
      3'd3: return m_sub(m_shift(s, 1), 1) ^ k;
      3'd4: return m_mix(s, 1);
      default: return s;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // test-vector string order -> byte 0 in bits [7:0]
  function automatic logic [127:0] vec(input logic [127:0] h);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = h[8*(15 - i) +: 8];
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // ---------------- compare helpers ----------------
  task automatic compare();
    n_cmp++;
    if (out_valid !== exp_valid) begin
      n_bad++;
      $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, exp_valid);
    end
    n_cmp++;
    if (out_result !== exp_result) begin
      n_bad++;
      $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_result);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [127:0] s, input logic [127:0] k);
    in_valid = v; in_op = op; in_state = s; in_key = k;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      exp_result = model(op, s, k);
      exp_tag    = tag_of(op);
    end else begin
      exp_tag = "R10";
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      in_valid = (i % 2 == 0); in_state = rnd128();
      @(posedge clk);
      exp_valid = 1'b0; exp_result = '0; exp_tag = "R1";
      @(negedge clk);
      compare();
    end
    rst = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] s, k;
    build_tables();
    @(negedge clk);
    do_reset(3);

    // R9/R3: published first-round vector, byte order anchored
    s = vec(128'h193de3bea0f4e22b9ac68d2ae9f84808);
    k = vec(128'ha0fafe1788542cb123a339392a6c7605);
    step(1'b1, 3'd0, s, k);
    n_cmp++;
    if (out_result !== vec(128'ha49c7ff2689f352b6b5bea43026a5049)) begin
      n_bad++;
      $display("FAIL R9 vector actual=%h expected=%h", out_result,
               vec(128'ha49c7ff2689f352b6b5bea43026a5049));
    end

    // R10: idle cycles hold the last result
    step(1'b0, 3'd2, rnd128(), rnd128());
    step(1'b0, 3'd4, rnd128(), rnd128());

    // R7/R8: key has no effect for inverse-mix and unused codes
    s = rnd128();
    for (int op = 4; op < 8; op++) begin
      step(1'b1, op[2:0], s, '0);
      step(1'b1, op[2:0], s, '1);
    end

    // all opcodes, back-to-back and with gaps (R2..R8, R10)
    for (int n = 0; n < 160; n++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 3'($urandom_range(0, 7)), rnd128(), rnd128());
    end

    // all-zero and all-one operands for every opcode
    for (int op = 0; op < 8; op++) begin
      step(1'b1, op[2:0], '0, '0);
      step(1'b1, op[2:0], '1, '1);
    end

    // R1: reset mid-stream clears the result
    step(1'b1, 3'd0, rnd128(), rnd128());
    do_reset(2);
    step(1'b0, 3'd0, rnd128(), rnd128());

    finish_run();
  end

endmodule